// File: doc/BRIEF.md
# Source/Sink Pattern Sequencer

The block holds a word-wide pattern store and two engines that share it. The source engine plays the low byte of consecutive words onto eight timing-command outputs, one word per clock, from word zero up to a programmable end word. It either stops there or, in cyclic mode, jumps back to word zero and keeps going. The sink engine records the eight live command signals into the high byte of consecutive words, one sample per clock, from word zero to the last word of the store.

Control arrives as plain level inputs that mirror bits of a control register. Two of them start a run on a 0-to-1 change only: the sequencer start and the sink start. The sink start launches the source as well. A rising trigger bit on the live inputs can also start the sink, but only when its enable is set. Two level resets abort the source and the sink. A host port reads and writes whole words. The memory has no reset and must be filled by software before use. A host access made while either engine is busy is held off until both are idle.

Top module: `pattern_sequencer`

## Requirements
- R1: A host write stores a 16-bit word; bits 7:0 are the source byte and bits 15:8 the sink byte. In each byte, bit 0 is trigger, 1 event-counter reset, 2 bunch-counter reset, 3 calibrate, 4 serial ID, 5 serial trigger type, 6 front-end reset and 7 spare. A later host read returns the word with `host_ack`.
- R2: When `ctl_seq_go` is seen high at a clock edge after being low at the one before, `src_busy` is high after that edge. The source byte of word k appears on `src_cmd` after the (k+3)th edge counted from and including that edge.
- R3: Each `src_cmd` bit is forced to 0 while its `ctl_out_en` bit is 0 at the edge that loads the output.
- R4: A start bit held high starts one run only; it must return to 0 before another start.
- R5: Without cyclic mode, one clock after the end word is presented `src_cmd` returns to 0 and `src_busy` falls in the same cycle.
- R6: With `ctl_cyclic` set, the word after the end word is word 0, and playback continues without a gap.
- R7: While `ctl_seq_reset` is high, the source is stopped one edge later, `src_cmd` is 0, and start edges seen during the reset are dropped.
- R8: A sink run writes the live command value sampled at each edge into the high byte of words 0 up to the last word in order, leaves the low bytes alone, and then clears `sink_busy`.
- R9: A rising `ctl_sink_go` starts the source together with the sink.
- R10: A rising `live_cmd[0]` starts the sink alone when `ctl_sink_trig_en` is 1, and has no effect when it is 0.
- R11: While `ctl_sink_reset` is high, the sink stops one edge later and stores no further samples.
- R12: A host request is served only when both engines are idle; `host_ack` never rises while a run is active.
- R13: After reset, `src_cmd` is 0 and `src_busy`, `sink_busy` and `host_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_out_en | input | 8 | Per-command source output enables |
| ctl_seq_reset | input | 1 | Level abort of the source |
| ctl_seq_go | input | 1 | Source start, acts on a rising value |
| ctl_cyclic | input | 1 | Wrap at the end word instead of stopping |
| ctl_end_addr | input | ADDR_W | Last word played |
| ctl_sink_reset | input | 1 | Level abort of the sink |
| ctl_sink_go | input | 1 | Sink and source start, acts on a rising value |
| ctl_sink_trig_en | input | 1 | Lets a rising live trigger start the sink |
| live_cmd | input | 8 | Live command signals recorded by the sink |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_we | input | 1 | Host write when 1, read when 0 |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | 16 | Host write word |
| host_rdata | output | 16 | Host read word, valid with host_ack |
| host_ack | output | 1 | One-cycle pulse when the access is done |
| src_cmd | output | 8 | Source command outputs |
| src_busy | output | 1 | Source run or its output pipeline active |
| sink_busy | output | 1 | Sink recording |

## Verification
The assertions assume that the host holds a request with stable address and data until it sees the acknowledge and then drops it. They also assume that the control bits change only between clock edges, and that the end address is not moved while a cyclic run uses it. The stimulus changes every input at the falling edge. It drops `host_req` at the same falling edge where the acknowledge is seen, and sets the end address and cyclic bit before a start. The memory words a check reads back are always written first, so no check depends on the undefined power-up contents.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int CMD_W = 8;
  typedef logic [CMD_W-1:0] cmd_t;

  // bit positions inside a source or sink byte
  localparam int CMD_TRIG  = 0;
  localparam int CMD_EVRST = 1;
  localparam int CMD_BCRST = 2;
  localparam int CMD_CAL   = 3;
  localparam int CMD_SERID = 4;
  localparam int CMD_SERTT = 5;
  localparam int CMD_FERST = 6;
  localparam int CMD_SPARE = 7;
endpackage

// File: rtl/seq_edge.sv
module seq_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= 1'b1;
      else     prev_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q[i];
  end
endmodule

// File: rtl/seq_dpram.sv
module seq_dpram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/seq_source.sv
module seq_source import seq_pkg::*; #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          start,
  input  logic          cyclic,
  input  logic [AW-1:0] end_addr,
  input  cmd_t          en,
  input  cmd_t          rd_data,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output cmd_t          cmd,
  output logic          busy
);
  logic          run_q;
  logic          rdv_q;
  logic          outv_q;
  logic [AW-1:0] addr_q;
  cmd_t          cmd_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_q  <= 1'b0;
      rdv_q  <= 1'b0;
      outv_q <= 1'b0;
      addr_q <= '0;
      cmd_q  <= '0;
    end else begin
      if (!run_q && !rdv_q && !outv_q && start) begin
        run_q  <= 1'b1;
        addr_q <= '0;
      end else if (run_q) begin
        if (addr_q == end_addr) begin
          if (cyclic) addr_q <= '0;
          else        run_q  <= 1'b0;
        end else begin
          addr_q <= addr_q + 1'b1;
        end
      end
      rdv_q  <= run_q;
      outv_q <= rdv_q;
      cmd_q  <= rdv_q ? (rd_data & en) : '0;
    end
  end

  assign rd_en   = run_q;
  assign rd_addr = addr_q;
  assign cmd     = cmd_q;
  assign busy    = run_q | rdv_q | outv_q;
endmodule

// File: rtl/seq_sink.sv
module seq_sink import seq_pkg::*; #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          start,
  input  cmd_t          live,
  output logic          we,
  output logic [AW-1:0] waddr,
  output cmd_t          wdata,
  output logic          busy
);
  localparam logic [AW-1:0] LAST = '1;

  logic          run_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_q  <= 1'b0;
      addr_q <= '0;
    end else if (!run_q && start) begin
      run_q  <= 1'b1;
      addr_q <= '0;
    end else if (run_q) begin
      addr_q <= addr_q + 1'b1;
      if (addr_q == LAST) run_q <= 1'b0;
    end
  end

  assign we    = run_q & ~clr;
  assign waddr = addr_q;
  assign wdata = live;
  assign busy  = run_q;
endmodule

// File: rtl/pattern_sequencer.sv
module pattern_sequencer import seq_pkg::*; #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CMD_W-1:0]  ctl_out_en,
  input  logic              ctl_seq_reset,
  input  logic              ctl_seq_go,
  input  logic              ctl_cyclic,
  input  logic [ADDR_W-1:0] ctl_end_addr,
  input  logic              ctl_sink_reset,
  input  logic              ctl_sink_go,
  input  logic              ctl_sink_trig_en,
  input  logic [CMD_W-1:0]  live_cmd,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [2*CMD_W-1:0] host_wdata,
  output logic [2*CMD_W-1:0] host_rdata,
  output logic              host_ack,
  output logic [CMD_W-1:0]  src_cmd,
  output logic              src_busy,
  output logic              sink_busy
);
  localparam int NEDGE = 3;
  localparam int E_GO = 0, E_SGO = 1, E_TRG = 2;

  logic [NEDGE-1:0] rise;
  logic             src_start, sink_start;
  logic             src_rd_en;
  logic [ADDR_W-1:0] src_rd_addr;
  cmd_t             src_rdata, snk_rdata;
  logic             snk_we;
  logic [ADDR_W-1:0] snk_waddr;
  cmd_t             snk_wdata;
  logic             ack_q, host_fire, host_wr;

  seq_edge #(.W(NEDGE)) u_edge (
    .clk (clk),
    .rst (rst),
    .lvl ({live_cmd[CMD_TRIG], ctl_sink_go, ctl_seq_go}),
    .rise(rise)
  );

  assign src_start  = rise[E_GO] | rise[E_SGO];
  assign sink_start = rise[E_SGO] | (rise[E_TRG] & ctl_sink_trig_en);

  seq_source #(.AW(ADDR_W)) u_src (
    .clk     (clk),
    .rst     (rst),
    .clr     (ctl_seq_reset),
    .start   (src_start),
    .cyclic  (ctl_cyclic),
    .end_addr(ctl_end_addr),
    .en      (ctl_out_en),
    .rd_data (src_rdata),
    .rd_en   (src_rd_en),
    .rd_addr (src_rd_addr),
    .cmd     (src_cmd),
    .busy    (src_busy)
  );

  seq_sink #(.AW(ADDR_W)) u_snk (
    .clk  (clk),
    .rst  (rst),
    .clr  (ctl_sink_reset),
    .start(sink_start),
    .live (live_cmd),
    .we   (snk_we),
    .waddr(snk_waddr),
    .wdata(snk_wdata),
    .busy (sink_busy)
  );

  // host is served only when both engines are idle
  assign host_fire = host_req & ~ack_q & ~src_busy & ~sink_busy;
  assign host_wr   = host_fire & host_we;

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else     ack_q <= host_fire;
  end

  seq_dpram #(.AW(ADDR_W), .DW(CMD_W)) u_src_mem (
    .clk  (clk),
    .we   (host_wr),
    .waddr(host_addr),
    .wdata(host_wdata[CMD_W-1:0]),
    .re   (src_rd_en | host_fire),
    .raddr(src_rd_en ? src_rd_addr : host_addr),
    .rdata(src_rdata)
  );

  seq_dpram #(.AW(ADDR_W), .DW(CMD_W)) u_snk_mem (
    .clk  (clk),
    .we   (snk_we | host_wr),
    .waddr(snk_we ? snk_waddr : host_addr),
    .wdata(snk_we ? snk_wdata : host_wdata[2*CMD_W-1:CMD_W]),
    .re   (host_fire),
    .raddr(host_addr),
    .rdata(snk_rdata)
  );

  assign host_rdata = {snk_rdata, src_rdata};
  assign host_ack   = ack_q;
endmodule

// File: rtl/pattern_sequencer_checker.sv
module pattern_sequencer_checker #(
  parameter int ADDR_W = 10
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] ctl_out_en,
  input logic       ctl_seq_reset,
  input logic       ctl_seq_go,
  input logic       ctl_sink_reset,
  input logic       ctl_sink_go,
  input logic       ctl_sink_trig_en,
  input logic [7:0] live_cmd,
  input logic       host_ack,
  input logic [7:0] src_cmd,
  input logic       src_busy,
  input logic       sink_busy
);
  // R13: quiet outputs after a reset edge
  a_r13_reset_quiet: assert property (@(posedge clk)
    rst |=> (src_cmd == 8'h00 && !src_busy && !sink_busy && !host_ack));

  // R3: a disabled bit is never driven
  a_r3_mask: assert property (@(posedge clk) disable iff (rst)
    (src_cmd & ~$past(ctl_out_en)) == 8'h00);

  // R5: no command leaves an idle source
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !src_busy |-> src_cmd == 8'h00);

  // R7: source reset stops the run
  a_r7_reset_stops: assert property (@(posedge clk) disable iff (rst)
    ctl_seq_reset |=> (!src_busy && src_cmd == 8'h00));

  // R11: sink reset stops recording
  a_r11_sink_stops: assert property (@(posedge clk) disable iff (rst)
    ctl_sink_reset |=> !sink_busy);

  // R12: no host access during a run
  a_r12_no_ack_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(host_ack) |-> $past(!src_busy && !sink_busy));

  // R4, R9: a source run begins only on a start request
  a_r4_start_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(src_busy) |-> $past(ctl_seq_go || ctl_sink_go));

  // R10: a sink run begins only on sink start or an enabled trigger
  a_r10_sink_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(sink_busy) |-> $past(ctl_sink_go || (ctl_sink_trig_en && live_cmd[0])));
endmodule

bind pattern_sequencer pattern_sequencer_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .ctl_out_en      (ctl_out_en),
  .ctl_seq_reset   (ctl_seq_reset),
  .ctl_seq_go      (ctl_seq_go),
  .ctl_sink_reset  (ctl_sink_reset),
  .ctl_sink_go     (ctl_sink_go),
  .ctl_sink_trig_en(ctl_sink_trig_en),
  .live_cmd        (live_cmd),
  .host_ack        (host_ack),
  .src_cmd         (src_cmd),
  .src_busy        (src_busy),
  .sink_busy       (sink_busy)
);

// File: tb/pattern_sequencer_test.sv
module pattern_sequencer_test;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] ctl_out_en = '0;
  logic ctl_seq_reset = 0, ctl_seq_go = 0, ctl_cyclic = 0;
  logic [AW-1:0] ctl_end_addr = '0;
  logic ctl_sink_reset = 0, ctl_sink_go = 0, ctl_sink_trig_en = 0;
  logic [7:0] live_cmd = '0;
  logic host_req = 0, host_we = 0;
  logic [AW-1:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic host_ack;
  logic [7:0] src_cmd;
  logic src_busy, sink_busy;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    logic [15:0] exp;
    logic [15:0] mask;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #2 clk = ~clk;

  pattern_sequencer #(.ADDR_W(AW)) uut (.*);

  function automatic logic [7:0] lo_pat(int a);
    return 8'((a * 29) + 7);
  endfunction
  function automatic logic [7:0] sk_pat(int k);
    return 8'((k * 13) + 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: queue expectation, then hold the request until acknowledged
  task automatic host_access(input bit we, input int a, input logic [15:0] d,
                             input logic [15:0] exp, input logic [15:0] mask,
                             input string tag, output int waited);
    sb_item_t it;
    it.exp = exp; it.mask = mask; it.tag = tag;
    sb_q.push_back(it);
    host_we = we; host_addr = AW'(a); host_wdata = d; host_req = 1'b1;
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!host_ack);
    host_req = 1'b0;
  endtask

  task automatic hwrite(input int a, input logic [15:0] d);
    int w;
    host_access(1'b1, a, d, 16'h0, 16'h0, "", w);
  endtask

  task automatic hread(input int a, input logic [15:0] exp, input logic [15:0] mask, input string tag);
    int w;
    host_access(1'b0, a, 16'h0, exp, mask, tag, w);
  endtask

  // monitor: pop and compare on every acknowledge
  always @(negedge clk) begin
    if (host_ack && sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      if (it.mask != 16'h0)
        chk(((host_rdata ^ it.exp) & it.mask) == 16'h0, it.tag,
            32'(host_rdata & it.mask), 32'(it.exp & it.mask));
    end
  end

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      report();
    end
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(src_cmd == 8'h00 && !src_busy && !sink_busy && !host_ack, "R13 reset state",
        {src_cmd, 1'b0, src_busy, sink_busy, host_ack}, 0);

    // R1: fill words 0..63, read a few back
    for (int a = 0; a < 64; a++) hwrite(a, {8'(a ^ 8'h5A), lo_pat(a)});
    for (int a = 0; a < 64; a += 9) hread(a, {8'(a ^ 8'h5A), lo_pat(a)}, 16'hFFFF, "R1 word round trip");
    @(negedge clk);

    // R2, R5, R4: one-shot playback of words 0..7
    ctl_out_en = 8'hFF; ctl_end_addr = 7; ctl_cyclic = 0;
    ctl_seq_go = 1'b1;
    @(negedge clk);
    chk(src_busy, "R2 busy after start", src_busy, 1);
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(src_cmd == lo_pat(k), "R2 playback", src_cmd, lo_pat(k));
    end
    @(negedge clk);
    chk(src_cmd == 8'h00 && !src_busy, "R5 stop after end", {src_cmd, 7'h0, src_busy}, 0);
    repeat (6) @(negedge clk);
    chk(!src_busy && src_cmd == 8'h00, "R4 held go no restart", src_busy, 0);
    ctl_seq_go = 1'b0;
    @(negedge clk);

    // R3: enables mask bits
    ctl_out_en = 8'h0F; ctl_end_addr = 3;
    ctl_seq_go = 1'b1;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk(src_cmd == (lo_pat(k) & 8'h0F), "R3 enable mask", src_cmd, lo_pat(k) & 8'h0F);
      @(negedge clk);
    end
    ctl_seq_go = 1'b0;
    repeat (3) @(negedge clk);

    // R6, R7: cyclic playback then source reset
    ctl_out_en = 8'hFF; ctl_end_addr = 2; ctl_cyclic = 1'b1;
    ctl_seq_go = 1'b1;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      chk(src_cmd == lo_pat(k % 3), "R6 cyclic wrap", src_cmd, lo_pat(k % 3));
      @(negedge clk);
    end
    ctl_seq_go = 1'b0;
    ctl_seq_reset = 1'b1;
    @(negedge clk);
    chk(!src_busy && src_cmd == 8'h00, "R7 reset stops", {src_cmd, 7'h0, src_busy}, 0);
    ctl_seq_go = 1'b1;
    repeat (3) @(negedge clk);
    chk(!src_busy, "R7 go during reset dropped", src_busy, 0);
    ctl_seq_reset = 1'b0;
    repeat (3) @(negedge clk);
    chk(!src_busy && src_cmd == 8'h00, "R7 no start after reset release", src_busy, 0);
    ctl_seq_go = 1'b0; ctl_cyclic = 1'b0;
    @(negedge clk);

    // R12: host read stalled by a run
    ctl_end_addr = 40;
    ctl_seq_go = 1'b1;
    @(negedge clk);
    host_access(1'b0, 5, 16'h0, {8'(5 ^ 8'h5A), lo_pat(5)}, 16'hFFFF, "R12 stalled read data", w);
    chk(w >= 40 && !src_busy, "R12 host stalled until idle", w, 40);
    ctl_seq_go = 1'b0;
    @(negedge clk);

    // R8, R9: sink run records live values and launches the source
    ctl_end_addr = 5;
    ctl_sink_go = 1'b1;
    @(negedge clk);
    chk(sink_busy && src_busy, "R9 sink go starts both", {sink_busy, src_busy}, 2'b11);
    ctl_sink_go = 1'b0;
    live_cmd = sk_pat(0);
    for (int k = 1; k < DEPTH; k++) begin
      @(negedge clk);
      live_cmd = sk_pat(k);
    end
    @(negedge clk);
    chk(!sink_busy, "R8 sink ends after last word", sink_busy, 0);
    live_cmd = 8'h00;
    for (int a = 0; a < 64; a++) hread(a, {sk_pat(a), lo_pat(a)}, 16'hFFFF, "R8 sink byte, source byte kept");
    for (int a = 64; a < DEPTH; a += 7) hread(a, {sk_pat(a), 8'h00}, 16'hFF00, "R8 sink byte");
    hread(DEPTH - 1, {sk_pat(DEPTH - 1), 8'h00}, 16'hFF00, "R8 last word");

    // R10: trigger ignored without enable
    @(negedge clk);
    live_cmd = 8'h81;
    @(negedge clk);
    chk(!sink_busy, "R10 trigger without enable", sink_busy, 0);
    live_cmd = 8'h00;
    ctl_sink_trig_en = 1'b1;
    @(negedge clk);
    live_cmd = 8'h81;
    @(negedge clk);
    chk(sink_busy && !src_busy, "R10 trigger starts sink only", {sink_busy, src_busy}, 2'b10);
    repeat (8) @(negedge clk);
    // R11: sink reset aborts after 8 samples (words 0..7)
    ctl_sink_reset = 1'b1;
    @(negedge clk);
    chk(!sink_busy, "R11 sink reset stops", sink_busy, 0);
    ctl_sink_reset = 1'b0;
    live_cmd = 8'h00;
    ctl_sink_trig_en = 1'b0;
    @(negedge clk);
    hread(3, {8'h81, lo_pat(3)}, 16'hFFFF, "R10 trigger run recorded");
    hread(7, {8'h81, lo_pat(7)}, 16'hFFFF, "R11 last word before reset");
    hread(9, {sk_pat(9), lo_pat(9)}, 16'hFFFF, "R11 no sample after reset");
    hread(20, {sk_pat(20), lo_pat(20)}, 16'hFFFF, "R11 later word kept");

    repeat (3) @(negedge clk);
    done = 1;
    report();
  end
endmodule